// File: doc/BRIEF.md
# Memory-Mapped Machine Timer

This block gives a processor core a wall-clock time base and a timer interrupt. It holds a 64-bit free-running time counter and a 64-bit compare value. The counter advances by one on each cycle where the tick-enable input is high. The timer interrupt output is a level signal. It is high whenever the counter is at or above the compare value, using a 64-bit unsigned compare. It stays high until software writes a compare value beyond the current count.

Software reaches the block over a plain 32-bit memory-mapped bus with byte write strobes. Each 64-bit register appears as two 32-bit words, low and high. Reads return data in the same cycle as the request. A one-bit software-interrupt register is included when the `HAS_SOFT` parameter is set. The block decodes a 64 KiB window that starts at 0x02000000.

Because the compare value changes one half at a time, a program must follow a set write order, or an interrupt may fire before the update is complete. The order is:

1. Write 0xFFFFFFFF to the low half.
2. Write the high half.
3. Write the final low half.

Top module: `mach_timer`

## Requirements
- R1: After reset, the time counter is zero and the compare value is all ones. `timerIrq` and `softIrq` are low.
- R2: The time counter rises by exactly one on each clock edge where `tickEn` is high and no write to a time word occurs. The low word carries into the high word on that same edge. With `tickEn` low and no write, the counter holds.
- R3: `timerIrq` is high exactly when time >= compare, as an unsigned 64-bit compare. It reflects register values in the cycle after the edge that changed them.
- R4: Registers are decoded only inside the window 0x02000000 to 0x0200FFFF, at these offsets:
  - 0x0000: software interrupt
  - 0x4000: compare low
  - 0x4004: compare high
  - 0xBFF8: time low
  - 0xBFFC: time high

  A read of any other address returns zero. A write to any other address changes nothing. `busRdata` is zero when `busSel` is low or `busWr` is high.
- R5: A write changes only the addressed 32-bit word. Within that word, only the bytes whose strobe bit is set change. Strobe bit i covers data bits 8i+7..8i.
- R6: A write to either time word takes precedence over the tick on that edge. The written bytes load, and the counter does not increment on that edge.
- R7: Take compare above time. Then write 0xFFFFFFFF to compare low, then the new compare high, then the new compare low, with the new value still above time. `timerIrq` stays low through the whole sequence.
- R8: Bit 0 of the software-interrupt word drives `softIrq` and is written only when strobe bit 0 is set. Bits 31..1 of that word read as zero.
- R9: Once `timerIrq` is high, it stays high until a write moves the compare value above the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Advance the time counter this cycle |
| busSel | input | 1 | Bus request valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Write data |
| busStrb | input | 4 | Byte write strobes |
| busRdata | output | 32 | Read data, valid in the request cycle |
| timerIrq | output | 1 | Level timer interrupt |
| softIrq | output | 1 | Software interrupt |

## Verification
The hold and step properties assume that the counter never wraps past 2^64. The stimulus runs only tens of cycles, so this assumption holds. The properties treat any write request as a possible register change, even one to an unmapped address. This means they only constrain cycles with no write at all. The bench drives every request as a single-cycle operation and changes inputs only at the falling edge, so each write lands on exactly one rising edge.

// File: rtl/mach_timer_pkg.sv
package mach_timer_pkg;
  localparam int WORD_W = 32;
  localparam int STRB_W = WORD_W / 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SOFT,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_TIME_LO,
    SEL_TIME_HI
  } regSel_e;

  typedef struct packed {
    logic              wrSoft;
    logic              wrCmpLo;
    logic              wrCmpHi;
    logic              wrTimeLo;
    logic              wrTimeHi;
    logic [STRB_W-1:0] byteEn;
    regSel_e           rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/mach_timer_ctrl.sv
module mach_timer_ctrl
  import mach_timer_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h0200_0000,
  parameter int          REGION_BITS = 16,
  parameter int unsigned SOFT_OFS    = 32'h0000,
  parameter int unsigned CMP_OFS     = 32'h4000,
  parameter int unsigned TIME_OFS    = 32'hBFF8,
  parameter bit          HAS_SOFT    = 1'b1
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [31:0]       busAddr,
  input  logic [STRB_W-1:0] busStrb,
  output ctrlStrobes_t      strobes
);
  localparam logic [REGION_BITS-1:0] OFS_SOFT    = SOFT_OFS[REGION_BITS-1:0];
  localparam logic [REGION_BITS-1:0] OFS_CMP_LO  = CMP_OFS[REGION_BITS-1:0];
  localparam logic [REGION_BITS-1:0] OFS_CMP_HI  = OFS_CMP_LO + REGION_BITS'(4);
  localparam logic [REGION_BITS-1:0] OFS_TIME_LO = TIME_OFS[REGION_BITS-1:0];
  localparam logic [REGION_BITS-1:0] OFS_TIME_HI = OFS_TIME_LO + REGION_BITS'(4);

  logic                   inRegion;
  logic [REGION_BITS-1:0] offs;
  regSel_e                hitSel;
  logic                   doWrite;

  assign inRegion = (busAddr[31:REGION_BITS] == BASE_ADDR[31:REGION_BITS]);
  assign offs     = busAddr[REGION_BITS-1:0];
  assign doWrite  = busSel && busWr;

  always_comb begin
    hitSel = SEL_NONE;
    if (inRegion) begin
      if (offs == OFS_SOFT && HAS_SOFT) hitSel = SEL_SOFT;
      else if (offs == OFS_CMP_LO)      hitSel = SEL_CMP_LO;
      else if (offs == OFS_CMP_HI)      hitSel = SEL_CMP_HI;
      else if (offs == OFS_TIME_LO)     hitSel = SEL_TIME_LO;
      else if (offs == OFS_TIME_HI)     hitSel = SEL_TIME_HI;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.wrSoft   = doWrite && (hitSel == SEL_SOFT);
    strobes.wrCmpLo  = doWrite && (hitSel == SEL_CMP_LO);
    strobes.wrCmpHi  = doWrite && (hitSel == SEL_CMP_HI);
    strobes.wrTimeLo = doWrite && (hitSel == SEL_TIME_LO);
    strobes.wrTimeHi = doWrite && (hitSel == SEL_TIME_HI);
    strobes.byteEn   = busStrb;
    strobes.rdSel    = (busSel && !busWr) ? hitSel : SEL_NONE;
  end
endmodule

// File: rtl/mach_timer_dp.sv
module mach_timer_dp
  import mach_timer_pkg::*;
#(
  parameter int TIME_W   = 2 * WORD_W,
  parameter bit HAS_SOFT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [WORD_W-1:0] busWdata,
  input  ctrlStrobes_t      strobes,
  output logic [WORD_W-1:0] busRdata,
  output logic [TIME_W-1:0] timeVal,
  output logic [TIME_W-1:0] cmpVal,
  output logic              timerIrq,
  output logic              softIrq
);
  localparam int HI_LSB = TIME_W / 2;

  function automatic logic [WORD_W-1:0] mergeBytes(
    input logic [WORD_W-1:0] oldW,
    input logic [WORD_W-1:0] newW,
    input logic [STRB_W-1:0] en
  );
    logic [WORD_W-1:0] res;
    res = oldW;
    for (int b = 0; b < STRB_W; b++) begin
      if (en[b]) res[8*b +: 8] = newW[8*b +: 8];
    end
    return res;
  endfunction

  logic [TIME_W-1:0] timeNext;
  logic              timeWrite;

  assign timeWrite = strobes.wrTimeLo || strobes.wrTimeHi;

  always_comb begin
    timeNext = timeVal;
    if (timeWrite) begin
      if (strobes.wrTimeLo)
        timeNext[HI_LSB-1:0] = mergeBytes(timeVal[HI_LSB-1:0], busWdata, strobes.byteEn);
      if (strobes.wrTimeHi)
        timeNext[TIME_W-1:HI_LSB] = mergeBytes(timeVal[TIME_W-1:HI_LSB], busWdata, strobes.byteEn);
    end else if (tickEn) begin
      timeNext = timeVal + TIME_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeVal <= '0;
    else       timeVal <= timeNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '1;
    end else begin
      if (strobes.wrCmpLo)
        cmpVal[HI_LSB-1:0] <= mergeBytes(cmpVal[HI_LSB-1:0], busWdata, strobes.byteEn);
      if (strobes.wrCmpHi)
        cmpVal[TIME_W-1:HI_LSB] <= mergeBytes(cmpVal[TIME_W-1:HI_LSB], busWdata, strobes.byteEn);
    end
  end

  generate
    if (HAS_SOFT) begin : g_soft
      logic softBit;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                    softBit <= 1'b0;
        else if (strobes.wrSoft && strobes.byteEn[0]) softBit <= busWdata[0];
      end
      assign softIrq = softBit;
    end else begin : g_nosoft
      assign softIrq = 1'b0;
    end
  endgenerate

  assign timerIrq = (timeVal >= cmpVal);

  always_comb begin
    case (strobes.rdSel)
      SEL_SOFT:    busRdata = {{(WORD_W-1){1'b0}}, softIrq};
      SEL_CMP_LO:  busRdata = cmpVal[HI_LSB-1:0];
      SEL_CMP_HI:  busRdata = cmpVal[TIME_W-1:HI_LSB];
      SEL_TIME_LO: busRdata = timeVal[HI_LSB-1:0];
      SEL_TIME_HI: busRdata = timeVal[TIME_W-1:HI_LSB];
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mach_timer_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
  parameter bit          HAS_SOFT  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic [3:0]  busStrb,
  output logic [31:0] busRdata,
  output logic        timerIrq,
  output logic        softIrq
);
  localparam int TIME_W = 2 * WORD_W;

  ctrlStrobes_t      strobes;
  logic [TIME_W-1:0] timeVal;
  logic [TIME_W-1:0] cmpVal;

  mach_timer_ctrl #(
    .BASE_ADDR (BASE_ADDR),
    .HAS_SOFT  (HAS_SOFT)
  ) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busStrb (busStrb),
    .strobes (strobes)
  );

  mach_timer_dp #(
    .TIME_W   (TIME_W),
    .HAS_SOFT (HAS_SOFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .busWdata (busWdata),
    .strobes  (strobes),
    .busRdata (busRdata),
    .timeVal  (timeVal),
    .cmpVal   (cmpVal),
    .timerIrq (timerIrq),
    .softIrq  (softIrq)
  );
endmodule

// File: rtl/mach_timer_chk.sv
module mach_timer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        tickEn,
  input logic        busSel,
  input logic        busWr,
  input logic [31:0] busRdata,
  input logic [63:0] timeVal,
  input logic [63:0] cmpVal,
  input logic        timerIrq,
  input logic        softIrq
);
  logic wrAny;
  assign wrAny = busSel && busWr;

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrAny) |=> $stable(timeVal)); // R2
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !wrAny) |=> (timeVal == $past(timeVal) + 64'd1)); // R2
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !wrAny) |=> timerIrq); // R9
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrAny |=> $stable(cmpVal)); // R5
  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrAny |=> $stable(softIrq)); // R8
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || busWr) |-> (busRdata == 32'd0)); // R4
endmodule

bind mach_timer mach_timer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .busSel   (busSel),
  .busWr    (busWr),
  .busRdata (busRdata),
  .timeVal  (timeVal),
  .cmpVal   (cmpVal),
  .timerIrq (timerIrq),
  .softIrq  (softIrq)
);

// File: tb/mach_timer_bench.sv
`timescale 1ns/1ps
module mach_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busStrb = '0;
  logic [31:0] busRdata;
  logic        timerIrq;
  logic        softIrq;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  mach_timer u_mach_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busStrb(busStrb),
    .busRdata(busRdata), .timerIrq(timerIrq), .softIrq(softIrq)
  );

  localparam logic [31:0] A_SOFT = 32'h0200_0000;
  localparam logic [31:0] A_CLO  = 32'h0200_4000;
  localparam logic [31:0] A_CHI  = 32'h0200_4004;
  localparam logic [31:0] A_TLO  = 32'h0200_BFF8;
  localparam logic [31:0] A_THI  = 32'h0200_BFFC;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  strb;
    logic        tick;
    logic [31:0] expRd;
    logic        expIrq;
    logic        expSoft;
  } vec_t;

  localparam int NVEC = 27;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, A_CLO,  32'h0,         4'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R1
    '{1'b0, A_CHI,  32'h0,         4'h0, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R1
    '{1'b0, A_TLO,  32'h0,         4'h0, 1'b1, 32'h0,         1'b0, 1'b0}, // R2
    '{1'b0, A_TLO,  32'h0,         4'h0, 1'b0, 32'h1,         1'b0, 1'b0}, // R2
    '{1'b1, A_CLO,  32'hFFFF_FFFF, 4'hF, 1'b0, 32'h0,         1'b0, 1'b0}, // R7
    '{1'b1, A_CHI,  32'h0,         4'hF, 1'b0, 32'h0,         1'b0, 1'b0}, // R7
    '{1'b1, A_CLO,  32'h3,         4'hF, 1'b0, 32'h0,         1'b0, 1'b0}, // R7
    '{1'b0, A_TLO,  32'h0,         4'h0, 1'b1, 32'h1,         1'b0, 1'b0}, // R3
    '{1'b0, A_TLO,  32'h0,         4'h0, 1'b1, 32'h2,         1'b1, 1'b0}, // R3
    '{1'b0, A_THI,  32'h0,         4'h0, 1'b1, 32'h0,         1'b1, 1'b0}, // R9
    '{1'b1, A_CLO,  32'hAABB_CC10, 4'h1, 1'b0, 32'h0,         1'b0, 1'b0}, // R5
    '{1'b1, A_TLO,  32'h0000_000F, 4'hF, 1'b1, 32'h0,         1'b0, 1'b0}, // R6
    '{1'b0, A_TLO,  32'h0,         4'h0, 1'b1, 32'h0000_000F, 1'b1, 1'b0}, // R6
    '{1'b1, A_TLO,  32'hFFFF_FFFF, 4'hF, 1'b0, 32'h0,         1'b1, 1'b0}, // R2
    '{1'b0, A_THI,  32'h0,         4'h0, 1'b1, 32'h0,         1'b1, 1'b0}, // R2
    '{1'b0, A_THI,  32'h0,         4'h0, 1'b0, 32'h1,         1'b1, 1'b0}, // R2 carry
    '{1'b0, A_TLO,  32'h0,         4'h0, 1'b0, 32'h0,         1'b1, 1'b0}, // R2 carry
    '{1'b1, A_SOFT, 32'hFFFF_FFFF, 4'hF, 1'b0, 32'h0,         1'b1, 1'b1}, // R8
    '{1'b0, A_SOFT, 32'h0,         4'h0, 1'b0, 32'h1,         1'b1, 1'b1}, // R8
    '{1'b0, 32'h0200_8000, 32'h0,  4'h0, 1'b0, 32'h0,         1'b1, 1'b1}, // R4
    '{1'b1, A_CHI,  32'h7777_7702, 4'h1, 1'b0, 32'h0,         1'b0, 1'b1}, // R9
    '{1'b0, A_CHI,  32'h0,         4'h0, 1'b0, 32'h2,         1'b0, 1'b1}, // R5
    '{1'b1, A_SOFT, 32'h0,         4'hE, 1'b0, 32'h0,         1'b0, 1'b1}, // R8
    '{1'b0, A_SOFT, 32'h0,         4'h0, 1'b0, 32'h1,         1'b0, 1'b1}, // R8
    '{1'b1, 32'h0300_4004, 32'h0,  4'hF, 1'b0, 32'h0,         1'b0, 1'b1}, // R4
    '{1'b0, A_CHI,  32'h0,         4'h0, 1'b0, 32'h2,         1'b0, 1'b1}, // R4
    '{1'b0, A_CLO,  32'h0,         4'h0, 1'b0, 32'h0000_0010, 1'b0, 1'b1}  // R5
  };

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  task automatic readWord(input logic [31:0] addr, input string req, input logic [31:0] exp);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr; tickEn = 1'b0;
    #1 checkVal(req, busRdata, exp);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 timerIrq", {31'b0, timerIrq}, 32'h0);
    checkVal("R1 softIrq", {31'b0, softIrq}, 32'h0);
    readWord(A_THI, "R1 time high", 32'h0);
    busSel = 1'b1; busWr = 1'b1; busAddr = A_CLO; busWdata = 32'h1234_5678; busStrb = 4'hF;
    #1 checkVal("R4 rdata during write", busRdata, 32'h0);
    busStrb = 4'h0;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    readWord(A_CLO, "R5 zero-strobe write keeps word", 32'hFFFF_FFFF);

    for (int i = 0; i < NVEC; i++) begin
      busSel = 1'b1; busWr = VEC[i].wr; busAddr = VEC[i].addr;
      busWdata = VEC[i].wdata; busStrb = VEC[i].strb; tickEn = VEC[i].tick;
      #1;
      if (!VEC[i].wr) checkVal($sformatf("R3/R4 vec%0d rdata", i), busRdata, VEC[i].expRd);
      @(negedge clk);
      checkVal($sformatf("R3 vec%0d timerIrq", i), {31'b0, timerIrq}, {31'b0, VEC[i].expIrq});
      checkVal($sformatf("R8 vec%0d softIrq", i), {31'b0, softIrq}, {31'b0, VEC[i].expSoft});
    end
    busSel = 1'b0; busWr = 1'b0; tickEn = 1'b0;

    rstN = 1'b0;
    @(negedge clk);
    checkVal("R1 re-reset timerIrq", {31'b0, timerIrq}, 32'h0);
    checkVal("R1 re-reset softIrq", {31'b0, softIrq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    readWord(A_CHI, "R1 re-reset compare high", 32'hFFFF_FFFF);
    readWord(A_TLO, "R1 re-reset time low", 32'h0);
    finishRun();
  end
endmodule